// File: doc/BRIEF.md
# ADC Control Register Bank

This block holds the host-visible control state of a delta-sigma converter front end. A parallel port carries a 3-bit register select, a write strobe, a read strobe and 16-bit write data. The read data is a combinational mux of the selected register. Behind the port are four kinds of storage: a configuration word, an IO word, and per-pair offset and full-scale calibration words. A conversion result register and a fixed identification value can be read but not written.

The block does more than store bits. It forces the front-end buffer on at higher gains, and it lets burnout currents through only while a buffered or amplified path exists. It maps the channel code onto one of three shared calibration pairs, flags the supply-monitor and reserved channel codes, and turns the IO word into drive and enable for two shared pins. Host writes to calibration words are only taken while the converter is quiet. A calibration result from the converter always lands in the active pair. Reading the conversion result marks the data as consumed until the next conversion-complete strobe.

Top module: `adc_regbank`

## Requirements
- R1: After reset: configuration reads 0x0710, IO reads 0x0000, the result reads 0x0000, every offset word reads 0x8000, every full-scale word reads the FS_RESET parameter, rdy_n is 1 and wr_err is 0.
- R2: Select codes: 3'b010 configuration, 3'b011 result, 3'b100 identification (ID_VAL in bits 7:0, upper bits 0), 3'b101 IO, 3'b110 offset, 3'b111 full-scale. Codes 3'b000 and 3'b001 read 0.
- R3: A configuration write keeps only bits 13 (burnout), 12 (unipolar), 10:8 (gain), 5 (reference detect), 4 (buffer) and 2:0 (channel), and stores 0 in bits 15, 14, 11, 7, 6 and 3. unipolar and refdet_en follow bits 12 and 5.
- R4: buf_en is 1 when the buffer bit is 1 or the gain code is 3'b010 or above. burnout_en is the burnout bit ANDed with buf_en. gain_code shows bits 10:8.
- R5: The channel code sets cal_pair as follows: 000 gives 0, 001 gives 1, 010 gives 2, 011 gives 0, and every other code gives 0. supply_mon is 1 only for code 111. ch_reserved is 1 only for codes 100 to 110.
- R6: Offset and full-scale reads and writes go to the active calibration pair. A host write is stored only while mode_quiet is 1.
- R7: cal_zs_vld writes cal_data into the active offset word and cal_fs_vld writes it into the active full-scale word, whatever the value of mode_quiet. A host write to the same kind of word in the same cycle is rejected.
- R8: conv_done loads conv_data into the result register and clears rdy_n on the next cycle. rd_en with select 3'b011 sets rdy_n on the next cycle, unless conv_done comes in the same cycle, in which case conv_done wins.
- R9: An IO write keeps bits 6:4 only. Both pin_oe bits equal bit 6. pin_out[0] is bit 4 AND bit 6, and pin_out[1] is bit 5 AND bit 6.
- R10: A rejected write changes no register, and wr_err is 1 for exactly the following cycle. A write is rejected when it targets the result, the identification value or an unassigned code, or when it is a locked or colliding calibration write.
- R11: rst_n is synchronous and active low. Asserting it for one clock mid-run restores every R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read-complete strobe |
| sel | input | 3 | Register select |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Selected register contents |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| mode_quiet | input | 1 | Converter is idle or powered down |
| cal_zs_vld | input | 1 | Zero-scale calibration result valid |
| cal_fs_vld | input | 1 | Full-scale calibration result valid |
| cal_data | input | CAL_W | Calibration result value |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | 16 | Conversion result |
| rdy_n | output | 1 | High while no unread result is held |
| gain_code | output | 3 | Stored gain code |
| buf_en | output | 1 | Effective buffer enable |
| burnout_en | output | 1 | Effective burnout current enable |
| unipolar | output | 1 | Unipolar coding selected |
| refdet_en | output | 1 | Reference detect enabled |
| cal_pair | output | 2 | Active calibration pair index |
| supply_mon | output | 1 | Supply monitor path selected (gain one sixth, internal reference) |
| ch_reserved | output | 1 | Reserved channel code stored |
| pin_oe | output | 2 | Shared pin output enables |
| pin_out | output | 2 | Shared pin output levels |

## Verification
The bench builds the block with FS_RESET set to 0x5A3C and ID_VAL set to 0x49 instead of their defaults. This keeps the full-scale reset value apart from the offset reset value and proves that both parameters reach the read port. CAL_W and NPAIR stay at 16 and 3, so all three pairs exist and every channel code, including the one that shares pair 0, is reachable. The random mix of mode_quiet with calibration strobes drives locked writes, writes that collide with calibration results, and reads of the result that coincide with conv_done.

// File: rtl/adc_regbank_pkg.sv
package adc_regbank_pkg;

    localparam int REG_W  = 16;
    localparam int IO_W   = 8;
    localparam int GAIN_W = 3;
    localparam int CH_W   = 3;
    localparam int PAIR_W = 2;
    localparam int NPIN   = 2;

    typedef enum logic [2:0] {
        SEL_NA0  = 3'b000,
        SEL_NA1  = 3'b001,
        SEL_CFG  = 3'b010,
        SEL_DATA = 3'b011,
        SEL_ID   = 3'b100,
        SEL_IO   = 3'b101,
        SEL_OFS  = 3'b110,
        SEL_FS   = 3'b111
    } sel_e;

    // configuration field positions
    localparam int CFG_BO     = 13;
    localparam int CFG_UNI    = 12;
    localparam int CFG_GAIN_L = 8;
    localparam int CFG_REFDET = 5;
    localparam int CFG_BUF    = 4;
    localparam int CFG_CH_L   = 0;

    localparam logic [REG_W-1:0] CFG_RST   = 16'h0710;
    localparam logic [REG_W-1:0] CFG_WMASK = 16'h3737;

    localparam int IO_EN_BIT = 6;
    localparam int IO_DAT_L  = 4;
    localparam logic [IO_W-1:0] IO_WMASK = 8'h70;

    typedef struct packed {
        logic              bo;
        logic              uni;
        logic [GAIN_W-1:0] gain;
        logic              refdet;
        logic              bufb;
        logic [CH_W-1:0]   ch;
    } cfg_f_t;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [IO_W-1:0]  io;
        logic [REG_W-1:0] data;
        logic             rdy_n;
        logic             wr_err;
    } top_st_t;

    localparam top_st_t TOP_RST = '{
        cfg:    CFG_RST,
        io:     '0,
        data:   '0,
        rdy_n:  1'b1,
        wr_err: 1'b0
    };

endpackage

// File: rtl/adc_cfg_decode.sv
module adc_cfg_decode
    import adc_regbank_pkg::*;
(
    input  cfg_f_t              f,
    output logic [GAIN_W-1:0]   gain_code,
    output logic                buf_en,
    output logic                burnout_en,
    output logic                unipolar,
    output logic                refdet_en,
    output logic [PAIR_W-1:0]   cal_pair,
    output logic                supply_mon,
    output logic                ch_reserved
);

    localparam logic [GAIN_W-1:0] AMP_GAIN_MIN = 3'd2;

    logic amp_on;

    always_comb begin
        amp_on      = (f.gain >= AMP_GAIN_MIN);
        gain_code   = f.gain;
        buf_en      = f.bufb | amp_on;
        burnout_en  = f.bo & (f.bufb | amp_on);
        unipolar    = f.uni;
        refdet_en   = f.refdet;
        supply_mon  = 1'b0;
        ch_reserved = 1'b0;
        unique case (f.ch)
            3'b000:  cal_pair = 2'd0;
            3'b001:  cal_pair = 2'd1;
            3'b010:  cal_pair = 2'd2;
            3'b011:  cal_pair = 2'd0;
            3'b111: begin
                cal_pair   = 2'd0;
                supply_mon = 1'b1;
            end
            default: begin
                cal_pair    = 2'd0;
                ch_reserved = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/adc_pin_ctl.sv
module adc_pin_ctl
    import adc_regbank_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic         drive_en,
    input  logic [N-1:0] drive_val,
    output logic [N-1:0] pin_oe,
    output logic [N-1:0] pin_out
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pin_oe[i]  = drive_en;
        assign pin_out[i] = drive_en & drive_val[i];
    end

endmodule

// File: rtl/adc_cal_bank.sv
module adc_cal_bank
    import adc_regbank_pkg::*;
#(
    parameter int               NPAIR     = 3,
    parameter int               CAL_W     = 16,
    parameter logic [CAL_W-1:0] OFS_RESET = 16'h8000,
    parameter logic [CAL_W-1:0] FS_RESET  = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] pair,
    input  logic              mode_quiet,
    input  logic              host_ofs_we,
    input  logic              host_fs_we,
    input  logic [CAL_W-1:0]  host_data,
    input  logic              cal_zs_vld,
    input  logic              cal_fs_vld,
    input  logic [CAL_W-1:0]  cal_data,
    output logic [CAL_W-1:0]  ofs_rd,
    output logic [CAL_W-1:0]  fs_rd,
    output logic              rej
);

    typedef struct packed {
        logic [NPAIR-1:0][CAL_W-1:0] ofs;
        logic [NPAIR-1:0][CAL_W-1:0] fs;
    } cal_st_t;

    cal_st_t st_d, st_q;
    logic    rej_ofs, rej_fs;

    always_comb begin
        st_d    = st_q;
        rej_ofs = host_ofs_we & (~mode_quiet | cal_zs_vld);
        rej_fs  = host_fs_we  & (~mode_quiet | cal_fs_vld);
        if (host_ofs_we && !rej_ofs) st_d.ofs[pair] = host_data;
        if (host_fs_we  && !rej_fs)  st_d.fs[pair]  = host_data;
        if (cal_zs_vld) st_d.ofs[pair] = cal_data;
        if (cal_fs_vld) st_d.fs[pair]  = cal_data;
        if (!rst_n) begin
            for (int i = 0; i < NPAIR; i++) begin
                st_d.ofs[i] = OFS_RESET;
                st_d.fs[i]  = FS_RESET;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ofs_rd = st_q.ofs[pair];
    assign fs_rd  = st_q.fs[pair];
    assign rej    = rej_ofs | rej_fs;

    AST_OFS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ofs_we && !mode_quiet && !cal_zs_vld) |=> $stable(st_q.ofs)); // R6
    AST_FS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_fs_we && !mode_quiet && !cal_fs_vld) |=> $stable(st_q.fs)); // R6
    AST_ZS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_zs_vld |=> (st_q.ofs[$past(pair)] == $past(cal_data))); // R7
    AST_FSCAL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fs_vld |=> (st_q.fs[$past(pair)] == $past(cal_data))); // R7

endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
    import adc_regbank_pkg::*;
#(
    parameter int               NPAIR     = 3,
    parameter int               CAL_W     = 16,
    parameter logic [7:0]       ID_VAL    = 8'h48,
    parameter logic [CAL_W-1:0] OFS_RESET = 16'h8000,
    parameter logic [CAL_W-1:0] FS_RESET  = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              wr_err,
    input  logic              mode_quiet,
    input  logic              cal_zs_vld,
    input  logic              cal_fs_vld,
    input  logic [CAL_W-1:0]  cal_data,
    input  logic              conv_done,
    input  logic [REG_W-1:0]  conv_data,
    output logic              rdy_n,
    output logic [GAIN_W-1:0] gain_code,
    output logic              buf_en,
    output logic              burnout_en,
    output logic              unipolar,
    output logic              refdet_en,
    output logic [PAIR_W-1:0] cal_pair,
    output logic              supply_mon,
    output logic              ch_reserved,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_out
);

    top_st_t          st_d, st_q;
    cfg_f_t           cfg_f;
    sel_e             sel_t;
    logic             host_ofs_we, host_fs_we, cal_rej, bad_wr;
    logic [CAL_W-1:0] ofs_rd, fs_rd;

    assign sel_t       = sel_e'(sel);
    assign host_ofs_we = wr_en && (sel_t == SEL_OFS);
    assign host_fs_we  = wr_en && (sel_t == SEL_FS);

    always_comb begin
        cfg_f.bo     = st_q.cfg[CFG_BO];
        cfg_f.uni    = st_q.cfg[CFG_UNI];
        cfg_f.gain   = st_q.cfg[CFG_GAIN_L +: GAIN_W];
        cfg_f.refdet = st_q.cfg[CFG_REFDET];
        cfg_f.bufb   = st_q.cfg[CFG_BUF];
        cfg_f.ch     = st_q.cfg[CFG_CH_L +: CH_W];
    end

    adc_cfg_decode u_dec (
        .f           (cfg_f),
        .gain_code   (gain_code),
        .buf_en      (buf_en),
        .burnout_en  (burnout_en),
        .unipolar    (unipolar),
        .refdet_en   (refdet_en),
        .cal_pair    (cal_pair),
        .supply_mon  (supply_mon),
        .ch_reserved (ch_reserved)
    );

    adc_cal_bank #(
        .NPAIR     (NPAIR),
        .CAL_W     (CAL_W),
        .OFS_RESET (OFS_RESET),
        .FS_RESET  (FS_RESET)
    ) u_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair        (cal_pair),
        .mode_quiet  (mode_quiet),
        .host_ofs_we (host_ofs_we),
        .host_fs_we  (host_fs_we),
        .host_data   (wdata[CAL_W-1:0]),
        .cal_zs_vld  (cal_zs_vld),
        .cal_fs_vld  (cal_fs_vld),
        .cal_data    (cal_data),
        .ofs_rd      (ofs_rd),
        .fs_rd       (fs_rd),
        .rej         (cal_rej)
    );

    adc_pin_ctl #(.N(NPIN)) u_pin (
        .drive_en  (st_q.io[IO_EN_BIT]),
        .drive_val (st_q.io[IO_DAT_L +: NPIN]),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    always_comb begin
        st_d   = st_q;
        bad_wr = 1'b0;
        if (wr_en) begin
            unique case (sel_t)
                SEL_CFG: st_d.cfg = wdata & CFG_WMASK;
                SEL_IO:  st_d.io  = wdata[IO_W-1:0] & IO_WMASK;
                SEL_OFS, SEL_FS: ;
                default: bad_wr = 1'b1;
            endcase
        end
        if (conv_done) begin
            st_d.data  = conv_data;
            st_d.rdy_n = 1'b0;
        end else if (rd_en && (sel_t == SEL_DATA)) begin
            st_d.rdy_n = 1'b1;
        end
        st_d.wr_err = bad_wr | cal_rej;
        if (!rst_n) st_d = TOP_RST;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        unique case (sel_t)
            SEL_CFG:  rdata = st_q.cfg;
            SEL_DATA: rdata = st_q.data;
            SEL_ID:   rdata = REG_W'(ID_VAL);
            SEL_IO:   rdata = REG_W'(st_q.io);
            SEL_OFS:  rdata = REG_W'(ofs_rd);
            SEL_FS:   rdata = REG_W'(fs_rd);
            default:  rdata = '0;
        endcase
    end

    assign wr_err = st_q.wr_err;
    assign rdy_n  = st_q.rdy_n;

    AST_BURNOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        burnout_en |-> buf_en); // R4
    AST_AMP_FORCES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code >= 3'd2) |-> buf_en); // R4
    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_t == SEL_CFG) |-> ((rdata & ~CFG_WMASK) == '0)); // R3
    AST_MON_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        supply_mon |-> !ch_reserved); // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !rdy_n); // R8
    AST_READ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_t == SEL_DATA && !conv_done) |=> rdy_n); // R8
    AST_PIN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)); // R9
    AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel_t == SEL_DATA || sel_t == SEL_ID)) |=> wr_err); // R10
    AST_RO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_t == SEL_DATA && !conv_done) |=> $stable(st_q.data)); // R10

endmodule

// File: tb/sim_adc_regbank.sv
module sim_adc_regbank;
    import adc_regbank_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] FS_R       = 16'h5A3C;
    localparam logic [7:0]  ID_R       = 8'h49;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, rd_en, mode_quiet, cal_zs_vld, cal_fs_vld, conv_done;
    logic [2:0]  sel;
    logic [15:0] wdata, rdata, cal_data, conv_data;
    logic        wr_err, rdy_n, buf_en, burnout_en, unipolar, refdet_en, supply_mon, ch_reserved;
    logic [2:0]  gain_code;
    logic [1:0]  cal_pair, pin_oe, pin_out;

    adc_regbank #(.ID_VAL(ID_R), .FS_RESET(FS_R)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .wdata(wdata), .rdata(rdata), .wr_err(wr_err), .mode_quiet(mode_quiet),
        .cal_zs_vld(cal_zs_vld), .cal_fs_vld(cal_fs_vld), .cal_data(cal_data),
        .conv_done(conv_done), .conv_data(conv_data), .rdy_n(rdy_n),
        .gain_code(gain_code), .buf_en(buf_en), .burnout_en(burnout_en),
        .unipolar(unipolar), .refdet_en(refdet_en), .cal_pair(cal_pair),
        .supply_mon(supply_mon), .ch_reserved(ch_reserved),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] m_cfg, m_data;
    logic [7:0]  m_io;
    logic [15:0] m_ofs [3];
    logic [15:0] m_fs  [3];
    logic        m_rdy_n, m_err;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp_v, $time);
        end
    endtask

    function automatic logic [1:0] f_pair(input logic [2:0] ch);
        case (ch)
            3'd1: return 2'd1;
            3'd2: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [15:0] f_rdata(input logic [2:0] s);
        logic [1:0] p;
        p = f_pair(m_cfg[2:0]);
        case (s)
            3'd2: return m_cfg;
            3'd3: return m_data;
            3'd4: return {8'h00, ID_R};
            3'd5: return {8'h00, m_io};
            3'd6: return m_ofs[p];
            3'd7: return m_fs[p];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_reset();
        m_cfg = 16'h0710; m_io = 8'h00; m_data = 16'h0000;
        m_rdy_n = 1'b1; m_err = 1'b0;
        for (int i = 0; i < 3; i++) begin
            m_ofs[i] = 16'h8000;
            m_fs[i]  = FS_R;
        end
    endtask

    task automatic model_clock();
        logic [1:0] p;
        logic       rej;
        if (!rst_n) begin
            model_reset();
        end else begin
            rej = 1'b0;
            p   = f_pair(m_cfg[2:0]);
            if (wr_en) begin
                case (sel)
                    3'd2: m_cfg = wdata & 16'h3737;
                    3'd5: m_io  = wdata[7:0] & 8'h70;
                    3'd6: if (mode_quiet && !cal_zs_vld) m_ofs[p] = wdata; else rej = 1'b1;
                    3'd7: if (mode_quiet && !cal_fs_vld) m_fs[p]  = wdata; else rej = 1'b1;
                    default: rej = 1'b1;
                endcase
            end
            if (cal_zs_vld) m_ofs[p] = cal_data;
            if (cal_fs_vld) m_fs[p]  = cal_data;
            if (conv_done) begin
                m_data = conv_data; m_rdy_n = 1'b0;
            end else if (rd_en && sel == 3'd3) begin
                m_rdy_n = 1'b1;
            end
            m_err = rej;
        end
    endtask

    task automatic check_all();
        logic [2:0] ch;
        logic [2:0] g;
        logic       be;
        ch = m_cfg[2:0];
        g  = m_cfg[10:8];
        be = m_cfg[4] | (g >= 3'd2);
        case (sel)
            3'd2:       chk("R3 cfg readback", rdata, f_rdata(sel));
            3'd3:       chk("R8 result readback", rdata, f_rdata(sel));
            3'd5:       chk("R9 io readback", rdata, f_rdata(sel));
            3'd6, 3'd7: chk("R6 cal word readback", rdata, f_rdata(sel));
            default:    chk("R2 select decode", rdata, f_rdata(sel));
        endcase
        chk("R4 gain_code", gain_code, g);
        chk("R4 buf_en", buf_en, be);
        chk("R4 burnout_en", burnout_en, m_cfg[13] & be);
        chk("R3 unipolar/refdet", {unipolar, refdet_en}, {m_cfg[12], m_cfg[5]});
        chk("R5 cal_pair", cal_pair, f_pair(ch));
        chk("R5 supply_mon", supply_mon, ch == 3'd7);
        chk("R5 ch_reserved", ch_reserved, ch >= 3'd4 && ch <= 3'd6);
        chk("R9 pin_oe", pin_oe, {2{m_io[6]}});
        chk("R9 pin_out", pin_out, {m_io[5] & m_io[6], m_io[4] & m_io[6]});
        chk("R8 rdy_n", rdy_n, m_rdy_n);
        chk("R10 wr_err", wr_err, m_err);
    endtask

    task automatic idle_in();
        wr_en = 0; rd_en = 0; sel = 3'd0; wdata = 0; mode_quiet = 1;
        cal_zs_vld = 0; cal_fs_vld = 0; cal_data = 0; conv_done = 0; conv_data = 0;
    endtask

    task automatic cycle();
        #1 check_all();
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d, input logic q);
        idle_in(); wr_en = 1; sel = s; wdata = d; mode_quiet = q;
        cycle();
    endtask

    task automatic rd(input logic [2:0] s);
        idle_in(); sel = s; cycle();
    endtask

    task automatic check_reset_state(input string tag);
        for (int s = 2; s < 8; s++) begin
            idle_in(); sel = 3'(s); #1;
            chk({tag, " reset read"}, rdata, f_rdata(3'(s)));
            @(negedge clk);
        end
        chk({tag, " reset cfg"}, m_cfg, 16'h0710);
        chk({tag, " reset rdy_n"}, rdy_n, 1'b1);
        chk({tag, " reset wr_err"}, wr_err, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h0000BEEF);
        idle_in();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_reset_state("R1");                  // R1

        wr(3'd2, 16'hFFFF, 1);                     // R3 reserved bits dropped
        rd(3'd2);
        wr(3'd2, 16'h2000, 1);                     // R4 gain 1, no buffer: burnout off
        rd(3'd2);
        wr(3'd2, 16'h2200, 1);                     // R4 gain 4 forces buffer
        rd(3'd2);
        wr(3'd2, 16'h0003, 1);                     // R5 channel 011 shares pair 0
        wr(3'd6, 16'h1234, 1);                     // R6 quiet write accepted
        rd(3'd6);
        wr(3'd2, 16'h0000, 1);
        rd(3'd6);
        wr(3'd7, 16'hBEEF, 0);                     // R6/R10 locked write rejected
        rd(3'd7);
        wr(3'd2, 16'h0007, 1);                     // R5 supply monitor
        wr(3'd2, 16'h0005, 1);                     // R5 reserved
        wr(3'd3, 16'hAAAA, 1);                     // R10 read-only target
        wr(3'd4, 16'h5555, 1);                     // R10 id target
        wr(3'd1, 16'h5555, 1);                     // R10 unassigned code
        wr(3'd5, 16'hFFFF, 1);                     // R9 pins driven
        wr(3'd5, 16'h0030, 1);                     // R9 pins analog
        idle_in(); conv_done = 1; conv_data = 16'hC0DE; cycle();   // R8
        idle_in(); rd_en = 1; sel = 3'd3; cycle();                 // R8
        idle_in(); rd_en = 1; sel = 3'd3; conv_done = 1; conv_data = 16'h0101; cycle(); // R8
        wr(3'd2, 16'h0001, 1);
        idle_in(); wr_en = 1; sel = 3'd6; wdata = 16'h7777; cal_zs_vld = 1; cal_data = 16'h4321; cycle(); // R7
        idle_in(); cal_fs_vld = 1; mode_quiet = 0; cal_data = 16'h6543; cycle(); // R7
        rd(3'd7);

        for (int i = 0; i < 600; i++) begin
            idle_in();
            wr_en      = ($urandom % 2) == 0;
            rd_en      = ($urandom % 2) == 0;
            sel        = 3'($urandom % 8);
            wdata      = 16'($urandom);
            mode_quiet = ($urandom % 2) == 0;
            cal_zs_vld = ($urandom % 8) == 0;
            cal_fs_vld = ($urandom % 8) == 0;
            cal_data   = 16'($urandom);
            conv_done  = ($urandom % 6) == 0;
            conv_data  = 16'($urandom);
            cycle();
        end

        wr(3'd2, 16'h3737, 1);
        idle_in(); rst_n = 0; cycle();             // R11 one-cycle mid-run reset
        rst_n = 1;
        check_reset_state("R11");                  // R11

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule